// File: doc/BRIEF.md
# Four-Port Parallel I/O Unit

This unit gives a processor four byte-wide parallel ports behind a small synchronous register bus. Every port has a data register and a direction register. Three ports (A, B, D) are fully general: each line is an input or an output, as its direction bit selects. Port C mixes general lines with special ones. Bit 3 is an inverted open-drain output. Bits 4 and 6 share a single open-drain line: bit 4 drives the line and bit 6 senses it. Bit 2 can be lent to an external serial unit as its shift clock.

Any bus read or write of the port D data register makes an active-low handshake strobe. This lets a parallel printer-style peripheral see each transfer. Each pin is modelled as an input level, an output value and an output enable. A line that nothing drives is taken to read 1, which stands for its pull-up resistor. In the bench, pin 4 of port C carries the drive of the shared line, and pin 6 of port C carries that line's level back in.

Top module: `pio_quad_port`

## Requirements
- R1: After reset all eight registers hold 0 and the strobe is high. Every general line is released (enable 0). Port C lines 3 and 4 are driven low (enable 1, value 0), because their direction bits are 0.
- R2: Address 2p selects the data register of port p and address 2p+1 selects its direction register, with A=0, B=1, C=2, D=3. A write stores the write data. A read puts the selected value on the read bus in the cycle after the read, and the read bus holds that value until the next read. A direction register reads back as it was written.
- R3: On a general line with direction 1, the enable is 1, the pin value is the data bit, and a read returns the data bit. With direction 0, the enable is 0 and a read returns the pin level through a two-flip-flop synchronizer. This applies to every bit of A, B and D, to bits 0, 1, 5 and 7 of C, and to bit 2 of C outside serial mode.
- R4: The strobe is low for one cycle, starting in the cycle after any read or write of address 6. Accesses on consecutive cycles keep it low. Accesses to any other address leave it high.
- R5: With C direction bit 3 at 0, line 3 is driven low, and a read of bit 3 returns 1.
- R6: With C direction bit 3 at 1, line 3 is driven low when data bit 3 is 1 and released when it is 0. A read of bit 3 returns data bit 3.
- R7: With C direction bit 4 at 0, the shared line is driven low through pin 4, and a read of bit 4 returns 1.
- R8: With C direction bit 4 at 1, the shared line is driven low when data bit 4 is 1 and released otherwise. A read of bit 4 returns data bit 4.
- R9: Pin 6 of port C is never driven. A read of C bit 6 always returns the synchronized level of the shared line, whatever C direction bit 6 holds.
- R10: While the serial-mode input is 1, C line 2 takes its enable and value from the serial unit's clock inputs, and a read of C bit 2 returns the synchronized pin level. The raw pin level is always available on the shift-clock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pin_in_a | input | 8 | Port A pin levels |
| pin_in_b | input | 8 | Port B pin levels |
| pin_in_c | input | 8 | Port C pin levels (bit 6 senses the shared line) |
| pin_in_d | input | 8 | Port D pin levels |
| pin_out_a | output | 8 | Port A output values |
| pin_out_b | output | 8 | Port B output values |
| pin_out_c | output | 8 | Port C output values |
| pin_out_d | output | 8 | Port D output values |
| pin_oe_a | output | 8 | Port A output enables |
| pin_oe_b | output | 8 | Port B output enables |
| pin_oe_c | output | 8 | Port C output enables (bit 4 drives the shared line) |
| pin_oe_d | output | 8 | Port D output enables |
| strb_n | output | 1 | Handshake strobe for port D data accesses, active low |
| ser_mode | input | 1 | Lends C line 2 to the serial unit when 1 |
| ser_clk_o | input | 1 | Shift clock value from the serial unit |
| ser_clk_oe | input | 1 | Shift clock enable from the serial unit |
| ser_clk_i | output | 1 | Raw level of C line 2 |

## Verification
The pin enables and values depend only on the registers, so a wrong data or direction bit shows at the pins one cycle after the write that set it. A fault in the read path or the synchronizer stays hidden until a read. A pin change reaches the read bus no sooner than three cycles later, so a delay of the wrong length appears as a read that returns the old or new level one cycle early or late. The bench keeps a reference model that it steps on every clock. It therefore catches an inverted open-drain term, a shared-line level that is not sensed, or a strobe with the wrong length, in the first cycle where the design and the model differ.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DW     = 8;
  localparam int NP     = 4;
  localparam int AW     = $clog2(2 * NP);
  localparam int IDX_C  = 2;
  localparam int IDX_D  = 3;
  localparam int C_SCLK = 2;
  localparam int C_OD   = 3;
  localparam int C_SH   = 4;
  localparam int C_SNS  = 6;

  typedef logic [DW-1:0] byte_t;
  typedef struct packed {
    byte_t oe;
    byte_t out;
  } drv_t;

  function automatic byte_t plain_read(byte_t dir, byte_t dat, byte_t pin);
    return (dir & dat) | (~dir & pin);
  endfunction

  function automatic drv_t plain_drive(byte_t dir, byte_t dat);
    drv_t r;
    r.oe  = dir;
    r.out = dat;
    return r;
  endfunction

  function automatic drv_t c_drive(byte_t dir, byte_t dat, logic smode,
                                   logic sclk_o, logic sclk_oe);
    drv_t r;
    r = plain_drive(dir, dat);
    if (smode) begin
      r.oe[C_SCLK]  = sclk_oe;
      r.out[C_SCLK] = sclk_o;
    end
    r.oe[C_OD]   = ~dir[C_OD] | dat[C_OD];
    r.out[C_OD]  = 1'b0;
    r.oe[C_SH]   = ~dir[C_SH] | dat[C_SH];
    r.out[C_SH]  = 1'b0;
    r.oe[C_SNS]  = 1'b0;
    r.out[C_SNS] = 1'b0;
    return r;
  endfunction

  function automatic byte_t c_read(byte_t dir, byte_t dat, byte_t pin, logic smode);
    byte_t r;
    r = plain_read(dir, dat, pin);
    if (smode) r[C_SCLK] = pin[C_SCLK];
    r[C_OD]  = dir[C_OD] ? dat[C_OD] : 1'b1;
    r[C_SH]  = dir[C_SH] ? dat[C_SH] : 1'b1;
    r[C_SNS] = pin[C_SNS];
    return r;
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  byte_t                 bus_wdata,
  input  logic [NP-1:0][DW-1:0] rd_view,
  output logic [NP-1:0][DW-1:0] dat,
  output logic [NP-1:0][DW-1:0] dir,
  output byte_t                 bus_rdata,
  output logic                  strb_n,
  output logic                  d_access
);
  logic [AW-2:0] port_sel;
  logic          is_dir;

  assign port_sel = bus_addr[AW-1:1];
  assign is_dir   = bus_addr[0];
  assign d_access = (bus_wr | bus_rd) && (int'(port_sel) == IDX_D) && !is_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat       <= '0;
      dir       <= '0;
      bus_rdata <= '0;
      strb_n    <= 1'b1;
    end else begin
      if (bus_wr) begin
        if (is_dir) dir[port_sel] <= bus_wdata;
        else        dat[port_sel] <= bus_wdata;
      end
      if (bus_rd) bus_rdata <= is_dir ? dir[port_sel] : rd_view[port_sel];
      strb_n <= !d_access;
    end
  end

  // R2
  dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_dir) |=> (dir[$past(port_sel)] == $past(bus_wdata)));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/pio_pin_ctl.sv
module pio_pin_ctl
  import pio_pkg::*;
#(
  parameter bit SPECIAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t dir,
  input  byte_t dat,
  input  byte_t pin_sync,
  input  logic  smode,
  input  logic  sclk_o,
  input  logic  sclk_oe,
  output byte_t oe,
  output byte_t out,
  output byte_t rd_view
);
  drv_t drv;

  assign drv     = SPECIAL ? c_drive(dir, dat, smode, sclk_o, sclk_oe)
                           : plain_drive(dir, dat);
  assign rd_view = SPECIAL ? c_read(dir, dat, pin_sync, smode)
                           : plain_read(dir, dat, pin_sync);
  assign oe  = drv.oe;
  assign out = drv.out;

  // R3
  plain_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir[0] |-> (oe[0] && out[0] == dat[0] && rd_view[0] == dat[0]));

  generate
    if (SPECIAL) begin : g_special
      // R5
      od_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir[C_OD] |-> (oe[C_OD] && !out[C_OD] && rd_view[C_OD]));
      // R6
      od_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir[C_OD] |-> (oe[C_OD] == dat[C_OD] && rd_view[C_OD] == dat[C_OD]));
      // R7
      sh_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir[C_SH] |-> (oe[C_SH] && !out[C_SH] && rd_view[C_SH]));
      // R8
      sh_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir[C_SH] |-> (oe[C_SH] == dat[C_SH] && rd_view[C_SH] == dat[C_SH]));
      // R9
      sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe[C_SNS] && rd_view[C_SNS] == pin_sync[C_SNS]);
      // R10
      sclk_lend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smode |-> (oe[C_SCLK] == sclk_oe && out[C_SCLK] == sclk_o));
    end
  endgenerate
endmodule

// File: rtl/pio_quad_port.sv
module pio_quad_port
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pin_in_a,
  input  logic [DW-1:0] pin_in_b,
  input  logic [DW-1:0] pin_in_c,
  input  logic [DW-1:0] pin_in_d,
  output logic [DW-1:0] pin_out_a,
  output logic [DW-1:0] pin_out_b,
  output logic [DW-1:0] pin_out_c,
  output logic [DW-1:0] pin_out_d,
  output logic [DW-1:0] pin_oe_a,
  output logic [DW-1:0] pin_oe_b,
  output logic [DW-1:0] pin_oe_c,
  output logic [DW-1:0] pin_oe_d,
  output logic          strb_n,
  input  logic          ser_mode,
  input  logic          ser_clk_o,
  input  logic          ser_clk_oe,
  output logic          ser_clk_i
);
  logic [NP-1:0][DW-1:0] pins_raw, pins_sync, dat, dir, rd_view, oe_all, out_all;
  logic                  d_access;

  assign pins_raw  = {pin_in_d, pin_in_c, pin_in_b, pin_in_a};
  assign ser_clk_i = pin_in_c[C_SCLK];

  pio_regfile u_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .rd_view, .dat, .dir, .bus_rdata, .strb_n, .d_access
  );

  generate
    for (genvar p = 0; p < NP; p++) begin : g_port
      pio_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
        .clk, .rst_n, .d(pins_raw[p]), .q(pins_sync[p])
      );
      pio_pin_ctl #(.SPECIAL(p == IDX_C)) u_ctl (
        .clk, .rst_n,
        .dir(dir[p]), .dat(dat[p]), .pin_sync(pins_sync[p]),
        .smode(ser_mode), .sclk_o(ser_clk_o), .sclk_oe(ser_clk_oe),
        .oe(oe_all[p]), .out(out_all[p]), .rd_view(rd_view[p])
      );
    end
  endgenerate

  assign pin_oe_a  = oe_all[0];
  assign pin_oe_b  = oe_all[1];
  assign pin_oe_c  = oe_all[2];
  assign pin_oe_d  = oe_all[3];
  assign pin_out_a = out_all[0];
  assign pin_out_b = out_all[1];
  assign pin_out_c = out_all[2];
  assign pin_out_d = out_all[3];

  // R4
  strobe_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_addr == AW'(2 * IDX_D)) |=> !strb_n);

  // R4
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!((bus_wr || bus_rd) && bus_addr == AW'(2 * IDX_D))) |=> strb_n);

  // R4
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_access |=> !strb_n);
endmodule

// File: tb/test_pio_quad_port.sv
module test_pio_quad_port;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in_a, pin_in_b, pin_in_c, pin_in_d;
  logic [7:0] pin_out_a, pin_out_b, pin_out_c, pin_out_d;
  logic [7:0] pin_oe_a, pin_oe_b, pin_oe_c, pin_oe_d;
  logic strb_n, ser_clk_i;
  logic ser_mode = 1'b0, ser_clk_o = 1'b0, ser_clk_oe = 1'b0;
  logic [7:0] ext [4];
  logic shared_line;
  int total = 0, bad = 0;
  logic running = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  // external world: pull-ups plus whatever the bench forces low
  assign shared_line = ext[2][6] & ~(pin_oe_c[4] & ~pin_out_c[4]);
  assign pin_in_a = ext[0];
  assign pin_in_b = ext[1];
  assign pin_in_c = {ext[2][7], shared_line, ext[2][5:0]};
  assign pin_in_d = ext[3];

  pio_quad_port i_pio_quad_port (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .pin_in_a, .pin_in_b, .pin_in_c, .pin_in_d,
    .pin_out_a, .pin_out_b, .pin_out_c, .pin_out_d,
    .pin_oe_a, .pin_oe_b, .pin_oe_c, .pin_oe_d,
    .strb_n, .ser_mode, .ser_clk_o, .ser_clk_oe, .ser_clk_i
  );

  // ---------------- reference model ----------------
  logic [7:0] m_dat [4], m_dir [4], m_s1 [4], m_s2 [4];
  logic [7:0] m_rd;
  logic m_strb_n;
  int   m_last_addr;

  function automatic logic [7:0] pins_now(int p);
    case (p)
      0: return pin_in_a;
      1: return pin_in_b;
      2: return pin_in_c;
      default: return pin_in_d;
    endcase
  endfunction

  function automatic logic exp_rbit(int p, int b);
    if (p == 2) begin
      if (b == 3 || b == 4) return m_dir[2][b] ? m_dat[2][b] : 1'b1;
      if (b == 6) return m_s2[2][6];
      if (b == 2 && ser_mode) return m_s2[2][2];
    end
    return m_dir[p][b] ? m_dat[p][b] : m_s2[p][b];
  endfunction

  function automatic logic [7:0] exp_view(int p);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = exp_rbit(p, b);
    return v;
  endfunction

  function automatic logic [1:0] exp_drive(int p, int b); // {oe, out}
    if (p == 2) begin
      if (b == 2 && ser_mode) return {ser_clk_oe, ser_clk_o};
      if (b == 3 || b == 4) return {(!m_dir[2][b]) || m_dat[2][b], 1'b0};
      if (b == 6) return 2'b00;
    end
    return {m_dir[p][b], m_dat[p][b]};
  endfunction

  function automatic string tag_of(int p, int b);
    if (p != 2) return "R3";
    case (b)
      2: return ser_mode ? "R10" : "R3";
      3: return m_dir[2][3] ? "R6" : "R5";
      4: return m_dir[2][4] ? "R8" : "R7";
      6: return "R9";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin
        m_dat[p] <= '0; m_dir[p] <= '0; m_s1[p] <= '0; m_s2[p] <= '0;
      end
      m_rd <= '0; m_strb_n <= 1'b1; m_last_addr <= 0;
    end else begin
      if (bus_rd) begin
        m_rd <= bus_addr[0] ? m_dir[bus_addr >> 1] : exp_view(int'(bus_addr >> 1));
        m_last_addr <= int'(bus_addr);
      end
      if (bus_wr) begin
        if (bus_addr[0]) m_dir[bus_addr >> 1] <= bus_wdata;
        else             m_dat[bus_addr >> 1] <= bus_wdata;
      end
      m_strb_n <= !((bus_wr || bus_rd) && bus_addr == 3'd6);
      for (int p = 0; p < 4; p++) begin
        m_s1[p] <= pins_now(p);
        m_s2[p] <= m_s1[p];
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] oe_of(int p);
    case (p) 0: return pin_oe_a; 1: return pin_oe_b; 2: return pin_oe_c; default: return pin_oe_d; endcase
  endfunction
  function automatic logic [7:0] out_of(int p);
    case (p) 0: return pin_out_a; 1: return pin_out_b; 2: return pin_out_c; default: return pin_out_d; endcase
  endfunction

  // compare every clock, one time unit after the edge
  always @(posedge clk) begin
    #1;
    if (running && rst_n) begin
      check(strb_n === m_strb_n, "R4 strobe", strb_n, m_strb_n);
      for (int b = 0; b < 8; b++) begin
        if (m_last_addr == 4)      check(bus_rdata[b] === m_rd[b], {tag_of(2, b), " read"}, bus_rdata, m_rd);
        else if (m_last_addr[0])   check(bus_rdata[b] === m_rd[b], "R2 read dir", bus_rdata, m_rd);
        else                       check(bus_rdata[b] === m_rd[b], "R3 read data", bus_rdata, m_rd);
      end
      for (int p = 0; p < 4; p++) begin
        for (int b = 0; b < 8; b++) begin
          logic [1:0] e;
          e = exp_drive(p, b);
          check({oe_of(p)[b], out_of(p)[b]} === e, {tag_of(p, b), " pin drive"},
                {oe_of(p)[b], out_of(p)[b]}, e);
        end
      end
      check(ser_clk_i === pin_in_c[2], "R10 shift clock in", ser_clk_i, pin_in_c[2]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(input logic [2:0] a, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); bus(a, 1'b1, 1'b0, d); endtask
  task automatic rd(input logic [2:0] a); bus(a, 1'b0, 1'b1, 8'h00); endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) ext[p] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1: reset state seen at the ports
    check(strb_n === 1'b1, "R1 strobe", strb_n, 1);
    check(pin_oe_a === 8'h00 && pin_oe_b === 8'h00 && pin_oe_d === 8'h00, "R1 enables",
          {pin_oe_a, pin_oe_b, pin_oe_d}, 0);
    check(pin_oe_c === 8'h18 && pin_out_c === 8'h00, "R1 port C", {pin_oe_c, pin_out_c}, 16'h1800);
    running = 1'b1;
    rd(3'd1); idle(1);
    check(bus_rdata === 8'h00, "R1 dir A read", bus_rdata, 0);

    // R2, R3: general ports
    wr(3'd1, 8'hFF); wr(3'd0, 8'h5A);
    wr(3'd3, 8'h0F); wr(3'd2, 8'h33);
    ext[1] = 8'hC3;
    wr(3'd7, 8'hF0); wr(3'd6, 8'hA5);
    ext[3] = 8'h96;
    idle(3);
    for (int a = 0; a < 8; a++) rd(3'(a));
    idle(2);
    ext[0] = 8'h0F; idle(2); rd(3'd0);
    wr(3'd1, 8'h00); idle(1); rd(3'd0); idle(3); rd(3'd0);
    ext[0] = 8'hE1; rd(3'd0); rd(3'd0); rd(3'd0); idle(1);

    // R4: strobe patterns
    rd(3'd6); idle(2);
    wr(3'd6, 8'h11); idle(2);
    rd(3'd6); wr(3'd6, 8'h22); rd(3'd6); idle(2);
    wr(3'd7, 8'h0F); rd(3'd7); rd(3'd4); idle(2);

    // R5, R7, R9: port C inputs
    ext[2] = 8'hA5;
    idle(3); rd(3'd4); idle(1);
    // R6, R8: open-drain outputs released
    wr(3'd5, 8'h18); wr(3'd4, 8'h00); idle(3); rd(3'd4); idle(1);
    wr(3'd4, 8'h10); idle(3); rd(3'd4); idle(1);
    wr(3'd4, 8'h08); idle(3); rd(3'd4); idle(1);
    // R9: direction bit 6 has no effect, external low pull
    wr(3'd5, 8'h58); idle(3); rd(3'd4);
    ext[2][6] = 1'b0; idle(3); rd(3'd4);
    ext[2][6] = 1'b1; idle(3); rd(3'd4); idle(1);

    // R10: serial clock handover
    wr(3'd5, 8'h04); wr(3'd4, 8'h00); idle(2);
    @(negedge clk); ser_mode = 1'b1; ser_clk_oe = 1'b1; ser_clk_o = 1'b1;
    idle(2);
    @(negedge clk); ser_clk_o = 1'b0; ext[2][2] = 1'b0;
    idle(3); rd(3'd4);
    @(negedge clk); ser_clk_oe = 1'b0; ext[2][2] = 1'b1;
    idle(3); rd(3'd4);
    @(negedge clk); ser_mode = 1'b0;
    idle(2); rd(3'd4); idle(3);

    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule